// File: doc/BRIEF.md
# Word FIFO with Fractional-Threshold Status Flags

A single-clock, word-wide first-in first-out buffer. A producer pushes words through a parallel write port with a one-cycle strobe. A downstream serializer sees the oldest stored word at all times, together with a valid indication, and takes it with a one-cycle pop pulse. The buffer keeps an explicit fill count and publishes four active-low status flags: empty, full, more-than-half-full, and one combined flag for the almost-empty and almost-full regions.

The depth is a power-of-two parameter, 256 by default, and the word width is a parameter as well. Every flag threshold is derived from the depth: one half, one eighth and seven eighths. A push into a full buffer is dropped without any effect. A pop from an empty buffer is ignored. Push and pop may come in the same cycle. By default the flags are registered from the next-state count, so all four flags change on the same edge as the count. A parameter selects a variant that decodes the flags combinationally from the current count.

Top module: `wfifo_flagged`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, fill_count is 0, rd_valid is 0, empty_n and almost_n are 0, and full_n and half_n are 1. The first word written after reset is the first word offered at rd_data.
- R2: A push (wr_stb=1) while the buffer holds DEPTH words is dropped. The count stays at DEPTH, and the dropped word never appears at rd_data.
- R3: A pop (rd_pop=1) while the buffer is empty is ignored. The count stays 0, rd_valid stays 0, and the read position is unchanged.
- R4: full_n is 0 exactly when fill_count equals DEPTH. empty_n is 0 exactly when fill_count is 0.
- R5: half_n is 0 exactly when fill_count is greater than DEPTH/2. For DEPTH=256, this is 129 words or more.
- R6: almost_n is 0 when fill_count is below DEPTH/8 or above 7*DEPTH/8, and 1 otherwise. For DEPTH=256, it is 0 for 0 to 31 and for 225 to 256.
- R7: A push and a pop in the same cycle, both accepted, leave fill_count unchanged. A push and a pop together on an empty buffer store the word and ignore the pop.
- R8: Words leave in the order they were accepted. The stored word is the value on wr_data in the cycle wr_stb is high.
- R9: rd_valid is 1 exactly when fill_count is nonzero. While rd_valid is 1, rd_data shows the oldest stored word.
- R10: fill_count, and the flags with it, change on the clock edge that ends the strobe cycle. The count rises by one for an accepted push alone, falls by one for an accepted pop alone, and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | Push strobe, one cycle per word |
| wr_data | input | WIDTH | Word to push |
| rd_pop | input | 1 | Pop strobe from the serializer |
| rd_valid | output | 1 | Head word is present |
| rd_data | output | WIDTH | Oldest stored word |
| fill_count | output | $clog2(DEPTH)+1 | Number of stored words |
| empty_n | output | 1 | Low when no word is stored |
| full_n | output | 1 | Low when DEPTH words are stored |
| half_n | output | 1 | Low when more than DEPTH/2 words are stored |
| almost_n | output | 1 | Low below DEPTH/8 or above 7*DEPTH/8 words |

## Verification
The properties take for granted that wr_stb and rd_pop are known 0/1 values in every clocked cycle. They also assume that reset is applied before the first strobe. Under these conditions the count and the flags can be related cycle by cycle. The stimulus changes all inputs only on the falling clock edge and holds each strobe for exactly one cycle. It also walks the fill level across every threshold in both directions, so that each flag edge is reached by a push and again by a pop.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;

   typedef struct packed {
      logic empty_n;
      logic full_n;
      logic half_n;
      logic almost_n;
   } fifo_flags_t;

   localparam fifo_flags_t FLAGS_AT_RESET = '{empty_n: 1'b0, full_n: 1'b1,
                                              half_n: 1'b1, almost_n: 1'b0};

endpackage

// File: rtl/wfifo_store.sv
module wfifo_store #(
   parameter int DEPTH = 256,
   parameter int WIDTH = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   // show-ahead: head word visible without a read latency
   assign rdata = cells[raddr];

endmodule

// File: rtl/wfifo_ptrs.sv
module wfifo_ptrs #(
   parameter int DEPTH = 256,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_stb,
   input  logic          rd_pop,
   output logic          wr_ok,
   output logic          rd_ok,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] cnt_d
);

   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

   assign wr_ok = wr_stb && (cnt_q != CNT_FULL);
   assign rd_ok = rd_pop && (cnt_q != '0);

   always_comb begin
      unique case ({wr_ok, rd_ok})
         2'b10:   cnt_d = cnt_q + CW'(1);
         2'b01:   cnt_d = cnt_q - CW'(1);
         default: cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + AW'(1);
         if (rd_ok) rd_ptr <= rd_ptr + AW'(1);
         cnt_q <= cnt_d;
      end
   end

   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_FULL && wr_stb && !rd_pop) |=> ($stable(cnt_q) && $stable(wr_ptr)))
      else $error("push accepted while full");

   p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && rd_pop && !wr_stb) |=> (cnt_q == '0 && $stable(rd_ptr)))
      else $error("pop accepted while empty");

   p_balanced_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && rd_pop && cnt_q != '0 && cnt_q != CNT_FULL) |=> $stable(cnt_q))
      else $error("count moved on balanced push and pop");

   p_push_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !rd_pop && cnt_q != CNT_FULL) |=> (cnt_q == $past(cnt_q) + CW'(1)))
      else $error("push did not raise count by one");

   p_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL)
      else $error("count above depth");

endmodule

// File: rtl/wfifo_flags.sv
module wfifo_flags
   import wfifo_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter bit REG_FLAGS = 1'b1,
   localparam int CW = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt_next,
   input  logic [CW-1:0] cnt_cur,
   output fifo_flags_t   flags
);

   localparam logic [CW-1:0] AT_FULL   = CW'(DEPTH);
   localparam logic [CW-1:0] AT_HALF   = CW'(DEPTH / 2);
   localparam logic [CW-1:0] LOW_EDGE  = CW'(DEPTH / 8);
   localparam logic [CW-1:0] HIGH_EDGE = CW'((7 * DEPTH) / 8);

   function automatic fifo_flags_t decode(input logic [CW-1:0] n);
      fifo_flags_t f;
      f.empty_n  = (n != '0);
      f.full_n   = (n != AT_FULL);
      f.half_n   = !(n > AT_HALF);
      f.almost_n = (n >= LOW_EDGE) && (n <= HIGH_EDGE);
      return f;
   endfunction

   generate
      if (REG_FLAGS) begin : g_registered
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags <= FLAGS_AT_RESET;
            else        flags <= decode(cnt_next);
         end
      end else begin : g_direct
         logic unused_ok;
         assign unused_ok = ^{clk, rst_n, cnt_next};
         assign flags = decode(cnt_cur);
      end
   endgenerate

   p_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags.full_n) == (cnt_cur == AT_FULL))
      else $error("full flag disagrees with count");

   p_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags.empty_n) == (cnt_cur == '0))
      else $error("empty flag disagrees with count");

   p_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags.half_n) == (cnt_cur > AT_HALF))
      else $error("half flag disagrees with count");

   p_almost_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flags.almost_n == (cnt_cur >= LOW_EDGE && cnt_cur <= HIGH_EDGE))
      else $error("almost flag disagrees with count");

endmodule

// File: rtl/wfifo_flagged.sv
module wfifo_flagged
   import wfifo_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int WIDTH = 16,
   parameter bit REG_FLAGS = 1'b1,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_pop,
   output logic             rd_valid,
   output logic [WIDTH-1:0] rd_data,
   output logic [CW-1:0]    fill_count,
   output logic             empty_n,
   output logic             full_n,
   output logic             half_n,
   output logic             almost_n
);

   initial begin
      assert (DEPTH >= 8 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two, at least 8");
      assert (WIDTH >= 1) else $error("WIDTH must be positive");
   end

   logic          wr_ok, rd_ok;
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt_q, cnt_d;
   fifo_flags_t   flags;

   wfifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (wr_stb),
      .rd_pop (rd_pop),
      .wr_ok  (wr_ok),
      .rd_ok  (rd_ok),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .cnt_q  (cnt_q),
      .cnt_d  (cnt_d)
   );

   wfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
      .clk   (clk),
      .we    (wr_ok),
      .waddr (wr_ptr),
      .wdata (wr_data),
      .raddr (rd_ptr),
      .rdata (rd_data)
   );

   wfifo_flags #(.DEPTH(DEPTH), .REG_FLAGS(REG_FLAGS)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_next (cnt_d),
      .cnt_cur  (cnt_q),
      .flags    (flags)
   );

   assign fill_count = cnt_q;
   assign empty_n    = flags.empty_n;
   assign full_n     = flags.full_n;
   assign half_n     = flags.half_n;
   assign almost_n   = flags.almost_n;
   assign rd_valid   = flags.empty_n;

   p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid == (fill_count != '0))
      else $error("valid disagrees with count");

   p_pop_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pop && !wr_stb && rd_valid) |=> (fill_count == $past(fill_count) - CW'(1)))
      else $error("pop did not lower count by one");

   logic unused_rd_ok;
   assign unused_rd_ok = rd_ok;

endmodule

// File: tb/sim_wfifo_flagged.sv
`timescale 1ns/100ps
module sim_wfifo_flagged;

   localparam int DEPTH = 256;
   localparam int WIDTH = 16;
   localparam int CW    = 9;

   typedef struct packed {
      logic        wr;
      logic        pop;
      logic [15:0] din;
      logic [8:0]  cnt;
      logic [3:0]  flg;   // {empty_n, full_n, half_n, almost_n}
      logic [15:0] head;
   } vec_t;

   // R7 and R3 cases are mixed into the walk
   localparam vec_t VECS [8] = '{
      '{1'b1, 1'b0, 16'h00A1, 9'd1, 4'b1110, 16'h00A1},
      '{1'b1, 1'b0, 16'h00B2, 9'd2, 4'b1110, 16'h00A1},
      '{1'b0, 1'b1, 16'h0000, 9'd1, 4'b1110, 16'h00B2},
      '{1'b1, 1'b1, 16'h00C3, 9'd1, 4'b1110, 16'h00C3},
      '{1'b0, 1'b1, 16'h0000, 9'd0, 4'b0110, 16'h0000},
      '{1'b0, 1'b1, 16'h0000, 9'd0, 4'b0110, 16'h0000},
      '{1'b1, 1'b1, 16'h00D4, 9'd1, 4'b1110, 16'h00D4},
      '{1'b0, 1'b1, 16'h0000, 9'd0, 4'b0110, 16'h0000}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_stb = 1'b0;
   logic [WIDTH-1:0] wr_data = '0;
   logic             rd_pop = 1'b0;
   logic             rd_valid;
   logic [WIDTH-1:0] rd_data;
   logic [CW-1:0]    fill_count;
   logic             empty_n, full_n, half_n, almost_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wfifo_flagged #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
      .rd_pop(rd_pop), .rd_valid(rd_valid), .rd_data(rd_data),
      .fill_count(fill_count), .empty_n(empty_n), .full_n(full_n),
      .half_n(half_n), .almost_n(almost_n)
   );

   function automatic logic [3:0] want_flags(input int n);
      logic [3:0] f;
      f[3] = (n != 0);                  // R4 empty
      f[2] = (n != DEPTH);              // R4 full
      f[1] = !(n > DEPTH / 2);          // R5
      f[0] = (n >= DEPTH / 8) && (n <= (7 * DEPTH) / 8);  // R6
      return f;
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic chk_state(input string tag, input int n);
      chk({tag, " count"}, 32'(fill_count), 32'(n));
      chk({tag, " flags"}, 32'({empty_n, full_n, half_n, almost_n}), 32'(want_flags(n)));
      chk({tag, " valid R9"}, 32'(rd_valid), 32'(n != 0));
   endtask

   task automatic step(input logic w, input logic p, input logic [15:0] d);
      @(negedge clk);
      wr_stb  = w;
      rd_pop  = p;
      wr_data = d;
      @(negedge clk);
      wr_stb  = 1'b0;
      rd_pop  = 1'b0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_state("R1 in reset", 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_state("R1 after release", 0);

      // vector walk
      foreach (VECS[k]) begin
         step(VECS[k].wr, VECS[k].pop, VECS[k].din);
         chk("R10 R7 R3 vec count", 32'(fill_count), 32'(VECS[k].cnt));
         chk("R4 R6 vec flags", 32'({empty_n, full_n, half_n, almost_n}), 32'(VECS[k].flg));
         if (VECS[k].cnt != 0) chk("R8 R9 vec head", 32'(rd_data), 32'(VECS[k].head));
      end

      // fill across all thresholds
      for (int i = 1; i <= DEPTH; i++) begin
         step(1'b1, 1'b0, 16'(16'h1000 + i));
         chk_state("R4 R5 R6 R10 fill", i);
      end
      chk("R8 head after fill", 32'(rd_data), 32'h1001);

      // push while full is dropped
      step(1'b1, 1'b0, 16'hDEAD);
      chk_state("R2 push at full", DEPTH);
      chk("R2 head unchanged", 32'(rd_data), 32'h1001);
      step(1'b1, 1'b1, 16'hBEEF);
      chk_state("R2 push+pop at full", DEPTH - 1);

      // drain, checking order and downward flag edges
      for (int i = 2; i <= DEPTH; i++) begin
         chk("R8 drain order", 32'(rd_data), 32'(16'h1000 + i));
         step(1'b0, 1'b1, 16'h0000);
         chk_state("R4 R5 R6 R10 drain", DEPTH - i);
      end

      // R3: pop on empty leaves read position alone
      step(1'b0, 1'b1, 16'h0000);
      chk_state("R3 pop at empty", 0);
      step(1'b1, 1'b0, 16'h7E57);
      chk("R3 head after ignored pop", 32'(rd_data), 32'h7E57);
      step(1'b0, 1'b1, 16'h0000);

      // mid-run reset
      step(1'b1, 1'b0, 16'h0111);
      step(1'b1, 1'b0, 16'h0222);
      step(1'b1, 1'b0, 16'h0333);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk_state("R1 mid reset", 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_state("R1 released", 0);
      step(1'b1, 1'b0, 16'h55AA);
      chk("R1 first word after reset", 32'(rd_data), 32'h55AA);
      chk_state("R1 one word", 1);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule